// File: doc/BRIEF.md
# Dual-Clock FIFO with Preset Almost Flags

This block buffers 36-bit words from a write port clocked by one clock to a read port clocked by an independent, unrelated clock. Its storage holds 64 words. Each port has an active-low chip select, a write/read direction input, an enable and a mailbox select. Together these decide whether a clock edge on that port performs an access. A read moves the oldest stored word into a registered output.

Four active-low status outputs report fill level. The full and almost-full outputs live in the write-clock domain. The empty and almost-empty outputs live in the read-clock domain. Each port sees the other port's pointer through a two-stage synchronizer, with the pointer carried in Gray code. A two-bit threshold code is captured when reset is released and sets the almost-threshold X to 4, 8, 12 or 16 words.

Reset is asynchronous and active low, with its release synchronized separately into each clock domain. It must be held for at least four edges of each clock.

Top module: `dcfifo_almost`

## Requirements
- R1: A write stores `a_data` on a rising `wclk` edge only when `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mbox`=0 and `full_n`=1; any other combination leaves the stored contents and the fill level unchanged.
- R2: A read loads the oldest word into `b_q` on a rising `rclk` edge only when `b_cs_n`=0, `b_wr`=0, `b_en`=1, `b_mbox`=0 and `empty_n`=1; otherwise `b_q` holds its value and no word is removed.
- R3: Words leave in the order they were written, and no more than 64 words are ever held.
- R4: The threshold X is captured from `thr_sel` on the rising edge of `rst_n`: code 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 12 and 2'b11 gives 16.
- R5: Once settled, `aempty_n` is 0 when the FIFO holds X or fewer words and 1 otherwise; `afull_n` is 0 when it holds 64−X or more words and 1 otherwise.
- R6: Once settled, `empty_n` is 0 exactly when the FIFO holds no words, and `full_n` is 0 exactly when it holds 64.
- R7: After a write into an empty FIFO, `empty_n` is still 0 after the first `rclk` edge following the write and is 1 after the second; the word can be read on the next edge.
- R8: After a read from a full FIFO, `full_n` is still 0 after the first `wclk` edge following the read and is 1 after the second.
- R9: While `rst_n` is 0, `empty_n`, `aempty_n` and `full_n` are 0, `afull_n` is 1 and `b_q` is 0; after `rst_n` rises, `full_n` is 0 after the first `wclk` edge and 1 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-port clock |
| rclk | input | 1 | Read-port clock, unrelated to `wclk` |
| rst_n | input | 1 | Asynchronous active-low reset; rising edge captures `thr_sel` |
| thr_sel | input | 2 | Almost-threshold code |
| a_cs_n | input | 1 | Write-port select, active low |
| a_wr | input | 1 | Write-port direction, 1 = write |
| a_en | input | 1 | Write-port enable |
| a_mbox | input | 1 | Write-port mailbox select; 1 blocks FIFO access |
| a_data | input | 36 | Write data |
| b_cs_n | input | 1 | Read-port select, active low |
| b_wr | input | 1 | Read-port direction, 0 = read |
| b_en | input | 1 | Read-port enable |
| b_mbox | input | 1 | Read-port mailbox select; 1 blocks FIFO access |
| b_q | output | 36 | Registered read data |
| full_n | output | 1 | Full, active low, in the `wclk` domain |
| afull_n | output | 1 | Almost full, active low, in the `wclk` domain |
| empty_n | output | 1 | Empty, active low, in the `rclk` domain |
| aempty_n | output | 1 | Almost empty, active low, in the `rclk` domain |

## Verification
A read that frees a slot in a full FIFO can occur while a write request is pending on the other clock. The write must still be refused for the two write-clock edges in which `full_n` stays low. The bench provokes this by holding a qualified write request steady while it issues one read. It samples `full_n` after each of the next two write edges. It then drains the whole FIFO and checks that the pending word was never stored, using the read order and the settled flag levels.

// File: rtl/dcfifo_almost.sv
`timescale 1ns/100ps
module dcfifo_almost #(
  parameter int DW      = 36,
  parameter int AW      = 6,
  parameter int TH_STEP = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [1:0]    thr_sel,
  input  logic          a_cs_n,
  input  logic          a_wr,
  input  logic          a_en,
  input  logic          a_mbox,
  input  logic [DW-1:0] a_data,
  input  logic          b_cs_n,
  input  logic          b_wr,
  input  logic          b_en,
  input  logic          b_mbox,
  output logic [DW-1:0] b_q,
  output logic          full_n,
  output logic          afull_n,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] thr;
  always_ff @(posedge rst_n) thr <= PW'((32'(thr_sel) + 1) * TH_STEP);

  logic [1:0] wrs, rrs;
  logic wrst_n, rrst_n;
  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) wrs <= '0; else wrs <= {wrs[0], 1'b1};
  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) rrs <= '0; else rrs <= {rrs[0], 1'b1};
  assign wrst_n = wrs[1];
  assign rrst_n = rrs[1];

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rg1, rg2, wg1, wg2;
  logic [PW-1:0] wcnt, rcnt, wbin_nx, rbin_nx;
  logic wr_go, rd_go;

  assign wr_go   = !a_cs_n & a_wr & a_en & !a_mbox & full_n;
  assign rd_go   = !b_cs_n & !b_wr & b_en & !b_mbox & empty_n;
  assign wbin_nx = wbin + 1'b1;
  assign rbin_nx = rbin + 1'b1;

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; rg1 <= '0; rg2 <= '0;
    end else begin
      rg1 <= rgray;
      rg2 <= rg1;
      if (wr_go) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= a_data;

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; wg1 <= '0; wg2 <= '0; b_q <= '0;
    end else begin
      wg1 <= wgray;
      wg2 <= wg1;
      if (rd_go) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
        b_q   <= mem[rbin[AW-1:0]];
      end
    end

  assign wcnt     = wbin - g2b(rg2);
  assign rcnt     = g2b(wg2) - rbin;
  assign full_n   = wrst_n & (wcnt != PW'(DEPTH));
  assign afull_n  = !wrst_n | (wcnt < (PW'(DEPTH) - thr));
  assign empty_n  = rrst_n & (wg2 != rgray);
  assign aempty_n = rrst_n & (rcnt > thr);
endmodule

// File: rtl/dcfifo_almost_chk.sv
`timescale 1ns/100ps
module dcfifo_almost_chk #(
  parameter int DW    = 36,
  parameter int PW    = 7,
  parameter int DEPTH = 64
) (
  input logic          wclk,
  input logic          rclk,
  input logic          wrst_n,
  input logic          rrst_n,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] wcnt,
  input logic [DW-1:0] b_q
);
  assert_full_blocks_write_R1: assert property (@(posedge wclk) disable iff (!wrst_n)
    !full_n |=> wbin == $past(wbin));

  assert_empty_blocks_read_R2: assert property (@(posedge rclk) disable iff (!rrst_n)
    !empty_n |=> (rbin == $past(rbin)) && (b_q == $past(b_q)));

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
    wcnt <= PW'(DEPTH));

  assert_single_step_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
    PW'(wbin - $past(wbin)) <= PW'(1));

  assert_full_in_afull_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    !full_n |-> !afull_n);

  assert_empty_in_aempty_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
    !empty_n |-> !aempty_n);
endmodule

bind dcfifo_almost dcfifo_almost_chk #(.DW(DW), .PW(PW), .DEPTH(DEPTH)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrst_n(wrst_n), .rrst_n(rrst_n),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .wbin(wbin), .rbin(rbin), .wcnt(wcnt), .b_q(b_q)
);

// File: tb/dcfifo_almost_tb.sv
`timescale 1ns/100ps
module dcfifo_almost_tb;
  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b1;
  logic [1:0] thr_sel = 2'b01;
  logic a_cs_n = 1'b1, a_wr = 1'b0, a_en = 1'b0, a_mbox = 1'b0;
  logic [35:0] a_data = '0;
  logic b_cs_n = 1'b1, b_wr = 1'b1, b_en = 1'b0, b_mbox = 1'b0;
  logic [35:0] b_q;
  logic full_n, afull_n, empty_n, aempty_n;

  int n_chk = 0, n_fail = 0, seq = 0, xval = 8;
  logic [35:0] expq [$];

  dcfifo_almost u_dut (.*);

  always #5 wclk = ~wclk;
  initial begin #1.3; forever #6.5 rclk = ~rclk; end

  // one entry per step: {writes to issue, reads to issue}
  localparam logic [15:0] VEC [8] = '{16'h0300, 16'h0600, 16'h0001, 16'h2F00,
                                      16'h0100, 16'h0800, 16'h0100, 16'h0040};

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] pat();
    seq++;
    return {4'(seq), 32'(seq) * 32'h01010101 ^ 32'h5A5A5A5A};
  endfunction

  task automatic wr_try(input logic cs_n, input logic wr, input logic en,
                        input logic mbox, input logic [35:0] d);
    @(negedge wclk);
    a_cs_n = cs_n; a_wr = wr; a_en = en; a_mbox = mbox; a_data = d;
    if (!cs_n && wr && en && !mbox && full_n) expq.push_back(d);
    @(posedge wclk); #1;
    a_en = 1'b0; a_cs_n = 1'b1;
  endtask

  task automatic push(); wr_try(1'b0, 1'b1, 1'b1, 1'b0, pat()); endtask

  task automatic rd_try(input logic cs_n, input logic wr, input logic en, input logic mbox);
    logic ok;
    logic [35:0] prev;
    @(negedge rclk);
    b_cs_n = cs_n; b_wr = wr; b_en = en; b_mbox = mbox;
    ok = !cs_n && !wr && en && !mbox && empty_n;
    prev = b_q;
    @(posedge rclk); #1;
    b_en = 1'b0; b_cs_n = 1'b1; b_wr = 1'b1;
    if (ok) chk("R3 read order", b_q, expq.pop_front());
    else    chk("R2 b_q held on ignored read", b_q, prev);
  endtask

  task automatic pop(); rd_try(1'b0, 1'b0, 1'b1, 1'b0); endtask

  task automatic settle();
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    #1;
  endtask

  task automatic chk_flags();
    int c = expq.size();
    chk("R6 empty_n", empty_n, c > 0);
    chk("R6 full_n", full_n, c < 64);
    chk("R5 aempty_n", aempty_n, c > xval);
    chk("R5 afull_n", afull_n, c < 64 - xval);
  endtask

  task automatic do_reset(input logic [1:0] code);
    @(negedge wclk);
    rst_n = 1'b0; thr_sel = code;
    repeat (5) @(posedge rclk);
    repeat (5) @(posedge wclk);
    #1;
    expq.delete();
    chk("R9 empty_n in reset", empty_n, 0);
    chk("R9 aempty_n in reset", aempty_n, 0);
    chk("R9 full_n in reset", full_n, 0);
    chk("R9 afull_n in reset", afull_n, 1);
    chk("R9 b_q in reset", b_q, 0);
    @(negedge wclk);
    rst_n = 1'b1;
    xval = (int'(code) + 1) * 4;
    @(posedge wclk); #1;
    chk("R9 full_n after first edge", full_n, 0);
    @(posedge wclk); #1;
    chk("R9 full_n after second edge", full_n, 1);
    repeat (3) @(posedge rclk);
    #1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    do_reset(2'b01);
    chk_flags();

    for (int i = 0; i < 8; i++) begin
      repeat (int'(VEC[i][15:8])) push();
      repeat (int'(VEC[i][7:0])) pop();
      settle();
      chk_flags();
    end

    // R1: writes missing one qualifier each
    wr_try(1'b1, 1'b1, 1'b1, 1'b0, 36'h111111111);
    wr_try(1'b0, 1'b0, 1'b1, 1'b0, 36'h222222222);
    wr_try(1'b0, 1'b1, 1'b0, 1'b0, 36'h333333333);
    wr_try(1'b0, 1'b1, 1'b1, 1'b1, 36'h444444444);
    settle();
    chk("R1 ignored writes keep empty_n low", empty_n, 0);
    push(); push();
    settle();
    // R2: reads missing one qualifier each
    rd_try(1'b1, 1'b0, 1'b1, 1'b0);
    rd_try(1'b0, 1'b1, 1'b1, 1'b0);
    rd_try(1'b0, 1'b0, 1'b0, 1'b0);
    rd_try(1'b0, 1'b0, 1'b1, 1'b1);
    settle();
    chk("R2 ignored reads keep empty_n high", empty_n, 1);
    chk_flags();
    pop(); pop();
    settle();
    chk_flags();

    // R7: empty-flag latency
    begin
      logic [35:0] d = pat();
      @(negedge wclk);
      a_cs_n = 1'b0; a_wr = 1'b1; a_en = 1'b1; a_mbox = 1'b0; a_data = d;
      expq.push_back(d);
      @(posedge wclk);
      fork begin @(negedge wclk); a_en = 1'b0; a_cs_n = 1'b1; end join_none
      @(posedge rclk); @(negedge rclk);
      chk("R7 empty_n after first read edge", empty_n, 0);
      @(posedge rclk); @(negedge rclk);
      chk("R7 empty_n after second read edge", empty_n, 1);
      pop();
    end
    settle();

    // R8 with R1: read from full while a qualified write waits
    repeat (64) push();
    settle();
    chk_flags();
    @(negedge wclk);
    a_cs_n = 1'b0; a_wr = 1'b1; a_en = 1'b1; a_mbox = 1'b0; a_data = 36'hBADBADBAD;
    @(negedge rclk);
    b_cs_n = 1'b0; b_wr = 1'b0; b_en = 1'b1; b_mbox = 1'b0;
    @(posedge rclk);
    fork begin
      @(negedge rclk);
      b_en = 1'b0; b_cs_n = 1'b1; b_wr = 1'b1;
      chk("R3 read from full", b_q, expq.pop_front());
    end join_none
    @(posedge wclk); @(negedge wclk);
    chk("R8 full_n after first write edge", full_n, 0);
    @(posedge wclk); @(negedge wclk);
    chk("R8 full_n after second write edge", full_n, 1);
    a_en = 1'b0; a_cs_n = 1'b1;
    settle();
    chk_flags();
    repeat (63) pop();
    settle();
    chk_flags();

    // R4 and R5: the remaining threshold codes
    for (int c = 0; c < 4; c++) begin
      if (c == 1) continue;
      do_reset(2'(c));
      repeat (xval) push();
      settle();
      chk("R4 aempty_n at X words", aempty_n, 0);
      push();
      settle();
      chk("R4 aempty_n at X+1 words", aempty_n, 1);
      repeat (64 - 2 * xval - 2) push();
      settle();
      chk("R4 afull_n at 63-X words", afull_n, 1);
      push();
      settle();
      chk("R4 afull_n at 64-X words", afull_n, 0);
      chk_flags();
    end

    report();
    $finish;
  end

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end
endmodule